// File: doc/BRIEF.md
# Four-Lane 7:1 Pixel Serializer

The block turns one 28-bit pixel word per pixel-clock period into seven consecutive bits on each of four serial lanes, together with a forwarded clock lane that repeats every pixel period. It runs from two clocks. The pixel clock captures the parallel word. A bit clock at seven times the pixel rate, with its rising edges lined up with the pixel clock's rising edges, drives the shift registers. The analog drivers, the multiplying PLL and swing control are outside the block. It provides single-ended lane bits with per-lane output enables that a pad ring can turn into differential pairs.

A static edge-select input chooses whether the word is captured on the rising or the falling pixel-clock edge. A narrow mode sends 21-bit words on three lanes: it floats the fourth lane and discards the seven input bits that would feed it. An active-low power-down input forces every lane and the forwarded clock to a driven low level, and it takes priority over the narrow-mode float. When power-down is released, the outputs stay quiet until a word captured after the release reaches the shift registers. The bit-clock domain finds its framing by itself from a toggle flag raised in the pixel-clock domain.

Top module: `ser7_serializer`

## Requirements
- R1: Lane i carries input bits [7i+6 : 7i], so lane 0 takes bits 6..0, lane 1 bits 13..7, lane 2 bits 20..14 and lane 3 bits 27..21.
- R2: Within one frame of seven bit-clock cycles, each lane sends the highest bit of its group first and the lowest bit last.
- R3: While the outputs are live, the forwarded clock is high for the first four bit cycles of each frame and low for the last three (pattern 1111000, first slot first). Its rising edge coincides with the first data bit.
- R4: With edge_rise = 1, the word present at the rising pixel-clock edge is the one transmitted.
- R5: With edge_rise = 0, the word present at the falling pixel-clock edge is the one transmitted.
- R6: With narrow_mode = 1 and power up, lane 3 has lane_oe[3] = 0 and lane_o[3] = 0, input bits 27..21 have no effect, and lanes 0..2 carry their groups unchanged. With narrow_mode = 0, lane_oe = 4'b1111.
- R7: While pd_n = 0, lane_o = 0, fclk_o = 0 and lane_oe = 4'b1111, in both narrow and full mode.
- R8: A captured word's first bit leaves at the first pixel-clock rising edge after its capture edge, and its frame occupies the seven bit cycles from that edge.
- R9: After pd_n rises, the lanes and fclk_o stay low for every frame whose word was captured while pd_n was still low. The first word captured with pd_n high is sent in full.
- R10: While rst is high, lane_o = 0, fclk_o = 0 and lane_oe = 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate, rising edges aligned with pix_clk |
| pix_clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| pix_data | input | 28 | Parallel pixel word |
| edge_rise | input | 1 | 1 captures on the rising pixel edge, 0 on the falling edge |
| narrow_mode | input | 1 | 1 sends on three lanes and floats lane 3 |
| pd_n | input | 1 | Active-low power-down |
| lane_o | output | 4 | Serial data bit of each lane |
| lane_oe | output | 4 | Output enable of each lane |
| fclk_o | output | 1 | Forwarded clock bit |

## Verification
A word set up before pixel-clock rising edge n+1 (rising capture), or before the falling edge that follows it (falling capture), has its first bit on the lanes in the bit cycle that starts at rising edge n+2. Its seventh bit is in the cycle just before edge n+3. The bench drives each pixel period's two candidate words at fixed offsets, rebuilds every frame from samples taken in the middle of each of the seven bit cycles, and compares the result with the stimulus of the period two frames earlier. Power-down takes about two bit cycles to reach the outputs, and mode changes take effect at a frame boundary. For that reason, frames whose window spans a change of pd_n, narrow_mode or edge_rise are left unchecked, and each check relies on inputs that were stable for the whole frame.

// File: rtl/ser7_pkg.sv
`timescale 1ns/1ps
package ser7_pkg;
    localparam int LANE_CNT   = 4;
    localparam int SLOT_CNT   = 7;
    localparam int NARROW_CNT = 3;
    localparam int WORD_W     = LANE_CNT * SLOT_CNT;
    localparam int NARROW_W   = NARROW_CNT * SLOT_CNT;
    localparam int SLOT_W     = $clog2(SLOT_CNT);
    // bit-clock edges between a pixel rising edge and the toggle detection
    localparam int SYNC_DEPTH = 3;

    typedef struct packed {
        logic              live;
        logic [WORD_W-1:0] bits;
    } pix_word_t;

    typedef enum logic [1:0] {
        FR_HUNT,
        FR_DARK,
        FR_LIVE
    } frame_state_e;

    // high for the upper slots: first-sent slot is the MSB
    function automatic logic [SLOT_CNT-1:0] fwd_pattern();
        logic [SLOT_CNT-1:0] p;
        p = '0;
        for (int k = 0; k < SLOT_CNT; k++) begin
            if (k >= SLOT_CNT / 2) p[k] = 1'b1;
        end
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] keep_mask(logic narrow);
        logic [WORD_W-1:0] m;
        m = '1;
        if (narrow) begin
            for (int k = NARROW_W; k < WORD_W; k++) m[k] = 1'b0;
        end
        return m;
    endfunction
endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/1ps
module ser7_capture
    import ser7_pkg::*;
(
    input  logic              pix_clk,
    input  logic              rst,
    input  logic              edge_rise,
    input  logic              narrow,
    input  logic              pd_n,
    input  logic [WORD_W-1:0] din,
    output pix_word_t         word_o,
    output logic              tog_o
);
    pix_word_t next_w;
    pix_word_t rise_q;
    pix_word_t fall_q;

    always_comb begin
        next_w.live = pd_n;
        next_w.bits = din & keep_mask(narrow);
    end

    always_ff @(posedge pix_clk) begin
        if (rst) begin
            rise_q <= '0;
            tog_o  <= 1'b0;
        end else begin
            rise_q <= next_w;
            tog_o  <= ~tog_o;
        end
    end

    always_ff @(negedge pix_clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= next_w;
    end

    assign word_o = edge_rise ? rise_q : fall_q;
endmodule

// File: rtl/ser7_frame_ctl.sv
`timescale 1ns/1ps
module ser7_frame_ctl
    import ser7_pkg::*;
(
    input  logic      bit_clk,
    input  logic      rst,
    input  logic      tog_i,
    input  pix_word_t word_i,
    input  logic      pd_n,
    input  logic      narrow,
    output logic      load_o,
    output pix_word_t word_o,
    output logic      live_o,
    output logic      pd_ok_o,
    output logic      nar_ok_o
);
    localparam logic [SLOT_W-1:0] ALIGN_SLOT = SLOT_W'(SYNC_DEPTH % SLOT_CNT);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOT_CNT - 1);

    logic [2:0]        tsync;
    logic [1:0]        pd_s;
    logic [1:0]        nar_s;
    logic [SLOT_W-1:0] slot;
    pix_word_t         w1;
    frame_state_e      state;
    logic              edge_seen;

    assign edge_seen = tsync[2] ^ tsync[1];
    assign load_o    = (state != FR_HUNT) && (slot == LAST_SLOT);
    assign live_o    = (state == FR_LIVE);
    assign pd_ok_o   = pd_s[1];
    assign nar_ok_o  = nar_s[1];

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            tsync  <= '0;
            pd_s   <= '0;
            nar_s  <= '0;
            slot   <= '0;
            w1     <= '0;
            word_o <= '0;
            state  <= FR_HUNT;
        end else begin
            tsync  <= {tsync[1:0], tog_i};
            pd_s   <= {pd_s[0], pd_n};
            nar_s  <= {nar_s[0], narrow};
            w1     <= word_i;
            word_o <= w1;
            if (edge_seen)               slot <= ALIGN_SLOT;
            else if (slot == LAST_SLOT)  slot <= '0;
            else                         slot <= slot + 1'b1;
            case (state)
                FR_HUNT: if (edge_seen) state <= FR_DARK;
                default: begin
                    if (!pd_s[1])    state <= FR_DARK;
                    else if (load_o) state <= word_o.live ? FR_LIVE : FR_DARK;
                end
            endcase
        end
    end
endmodule

// File: rtl/ser7_lane_shift.sv
`timescale 1ns/1ps
module ser7_lane_shift #(
    parameter int W = 7
) (
    input  logic         bit_clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] par,
    output logic         ser_o
);
    logic [W-1:0] sh;

    always_ff @(posedge bit_clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= par;
        else           sh <= {sh[W-2:0], 1'b0};
    end

    assign ser_o = sh[W-1];
endmodule

// File: rtl/ser7_serializer.sv
`timescale 1ns/1ps
module ser7_serializer
    import ser7_pkg::*;
(
    input  logic              bit_clk,
    input  logic              pix_clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] pix_data,
    input  logic              edge_rise,
    input  logic              narrow_mode,
    input  logic              pd_n,
    output logic [LANE_CNT-1:0] lane_o,
    output logic [LANE_CNT-1:0] lane_oe,
    output logic              fclk_o
);
    pix_word_t cap_w;
    pix_word_t cur_w;
    logic      tog;
    logic      load;
    logic      live;
    logic      pd_ok;
    logic      nar_ok;
    logic [LANE_CNT-1:0] raw;
    logic      raw_clk;

    ser7_capture u_cap (
        .pix_clk  (pix_clk),
        .rst      (rst),
        .edge_rise(edge_rise),
        .narrow   (narrow_mode),
        .pd_n     (pd_n),
        .din      (pix_data),
        .word_o   (cap_w),
        .tog_o    (tog)
    );

    ser7_frame_ctl u_ctl (
        .bit_clk (bit_clk),
        .rst     (rst),
        .tog_i   (tog),
        .word_i  (cap_w),
        .pd_n    (pd_n),
        .narrow  (narrow_mode),
        .load_o  (load),
        .word_o  (cur_w),
        .live_o  (live),
        .pd_ok_o (pd_ok),
        .nar_ok_o(nar_ok)
    );

    for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
        localparam bit IS_EXTRA = (i >= NARROW_CNT);
        logic floated;
        ser7_lane_shift #(.W(SLOT_CNT)) u_sh (
            .bit_clk(bit_clk),
            .rst    (rst),
            .load   (load),
            .par    (cur_w.bits[i*SLOT_CNT +: SLOT_CNT]),
            .ser_o  (raw[i])
        );
        assign floated    = IS_EXTRA && nar_ok;
        assign lane_oe[i] = pd_ok ? !floated : 1'b1;
        assign lane_o[i]  = raw[i] & live & pd_ok & !floated;
    end

    ser7_lane_shift #(.W(SLOT_CNT)) u_fclk (
        .bit_clk(bit_clk),
        .rst    (rst),
        .load   (load),
        .par    (fwd_pattern()),
        .ser_o  (raw_clk)
    );

    assign fclk_o = raw_clk & live & pd_ok;
endmodule

// File: rtl/ser7_serializer_chk.sv
`timescale 1ns/1ps
module ser7_serializer_chk
    import ser7_pkg::*;
(
    input logic                bit_clk,
    input logic                rst,
    input logic                pd_n,
    input logic                narrow_mode,
    input logic                pd_ok,
    input logic [LANE_CNT-1:0] lane_o,
    input logic [LANE_CNT-1:0] lane_oe,
    input logic                fclk_o
);
    // R3: high phase lasts beyond its first slot unless power drops
    p_fclk_high_run_r3: assert property (@(posedge bit_clk) disable iff (rst)
        $rose(fclk_o) |=> (fclk_o || !pd_ok));

    // R3: low phase lasts beyond its first slot
    p_fclk_low_run_r3: assert property (@(posedge bit_clk) disable iff (rst)
        $fell(fclk_o) |=> !fclk_o);

    // R6: settled narrow mode floats the extra lane
    p_extra_lane_float_r6: assert property (@(posedge bit_clk) disable iff (rst)
        (narrow_mode && $past(narrow_mode) && $past(narrow_mode, 2) &&
         pd_n && $past(pd_n) && $past(pd_n, 2))
        |-> (!lane_oe[LANE_CNT-1] && !lane_o[LANE_CNT-1]));

    // R7: settled power-down drives everything low and enabled
    p_power_down_quiet_r7: assert property (@(posedge bit_clk) disable iff (rst)
        (!pd_n && !$past(pd_n) && !$past(pd_n, 2))
        |-> (lane_o == '0 && lane_oe == '1 && !fclk_o));
endmodule

bind ser7_serializer ser7_serializer_chk u_chk (
    .bit_clk    (bit_clk),
    .rst        (rst),
    .pd_n       (pd_n),
    .narrow_mode(narrow_mode),
    .pd_ok      (pd_ok),
    .lane_o     (lane_o),
    .lane_oe    (lane_oe),
    .fclk_o     (fclk_o)
);

// File: tb/tb_ser7_serializer.sv
`timescale 1ns/1ps
module tb_ser7_serializer;
    localparam int NPIX = 320;
    localparam int NARR = NPIX + 8;

    logic        bit_clk = 1'b0;
    logic        pix_clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] pix_data = '0;
    logic        edge_rise = 1'b1;
    logic        narrow_mode = 1'b0;
    logic        pd_n = 1'b0;
    logic [3:0]  lane_o;
    logic [3:0]  lane_oe;
    logic        fclk_o;

    int checks = 0;
    int failures = 0;
    bit mon_done = 1'b0;

    logic [27:0] wa [NARR];
    logic [27:0] wb [NARR];
    bit          pdv [NARR];
    bit          m18v[NARR];
    bit          esv [NARR];

    ser7_serializer dut (
        .bit_clk    (bit_clk),
        .pix_clk    (pix_clk),
        .rst        (rst),
        .pix_data   (pix_data),
        .edge_rise  (edge_rise),
        .narrow_mode(narrow_mode),
        .pd_n       (pd_n),
        .lane_o     (lane_o),
        .lane_oe    (lane_oe),
        .fclk_o     (fclk_o)
    );

    // 50 MHz bit clock; pixel clock at 1/7, rising edges aligned
    initial forever #10 bit_clk = ~bit_clk;
    initial begin
        #10;
        forever begin
            pix_clk = 1'b1; #70;
            pix_clk = 1'b0; #70;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [27:0] expect_word(int n);
        logic [27:0] w;
        w = esv[n] ? wa[n] : wb[n];
        if (m18v[n]) w[27:21] = 7'd0;
        return w;
    endfunction

    task automatic check_frame(input int n, input logic [6:0] fk,
                               input logic [27:0] rw, input logic [3:0] oe_s);
        logic [27:0] ew;
        logic [6:0]  ef;
        bit          stable;
        string       tag;
        if (n < 3 || n >= NPIX) return;
        stable = (m18v[n] == m18v[n+1]) && (m18v[n+1] == m18v[n+2]) &&
                 (esv[n] == esv[n+1]);
        if (pdv[n+1] && pdv[n+2]) begin
            if (!stable) return;
            if (pdv[n]) begin
                ew  = expect_word(n);
                ef  = 7'b1111000;
                tag = $sformatf("R1 R2 R8 %s%s", esv[n] ? "R4" : "R5",
                                m18v[n] ? " R6" : "");
            end else begin
                ew  = '0;
                ef  = '0;
                tag = "R9";
            end
            chk(fk == ef, pdv[n] ? "R3" : "R9", $sformatf("fclk frame %0d", n), 32'(fk), 32'(ef));
            chk(rw == ew, tag, $sformatf("word frame %0d", n), 32'(rw), 32'(ew));
            chk(oe_s == (m18v[n] ? 4'b0111 : 4'b1111), "R6",
                $sformatf("oe frame %0d", n), 32'(oe_s), m18v[n] ? 32'h7 : 32'hF);
        end else if (!pdv[n+1] && !pdv[n+2]) begin
            chk(fk == '0, "R7", $sformatf("fclk frame %0d", n), 32'(fk), 32'h0);
            chk(rw == '0, "R7", $sformatf("word frame %0d", n), 32'(rw), 32'h0);
            chk(oe_s == 4'hF, "R7", $sformatf("oe frame %0d", n), 32'(oe_s), 32'hF);
        end
    endtask

    // stimulus plan and driver
    initial begin
        int unsigned seed_tap;
        seed_tap = $urandom(32'd20240);
        for (int n = 0; n < NARR; n++) begin
            pdv[n]  = !(n < 6 || (n >= 240 && n < 260));
            m18v[n] = (n >= 120 && n < 260);
            esv[n]  = (n < 60) || (n >= 180 && n < 260) || (n >= 290);
            wa[n]   = 28'($urandom);
            wb[n]   = ($urandom % 2 == 0) ? wa[n] : 28'($urandom);
        end
        wa[10] = 28'h0000000;  wb[10] = 28'h0000000;
        wa[11] = 28'hFFFFFFF;  wb[11] = 28'hFFFFFFF;
        wa[12] = 28'h5555555;  wb[12] = 28'h5555555;
        wa[13] = 28'hAAAAAAA;  wb[13] = 28'hAAAAAAA;
        wa[70] = 28'hFFFFFFF;  wb[70] = 28'h0000000;   // R5 directed
        wa[30] = 28'h0000000;  wb[30] = 28'hFFFFFFF;   // R4 directed
        wa[130] = 28'hFFFFFFF; wb[130] = 28'hFFFFFFF;  // R6 ignored bits
        wa[200] = 28'hFE00000; wb[200] = 28'h01FFFFF;  // R6 with rising
        #90;  // first pixel rising edge is at 10 ns
        for (int n = 0; n < NARR; n++) begin
            if (n == 2) rst = 1'b0;
            pd_n        = pdv[n];
            narrow_mode = m18v[n];
            edge_rise   = esv[n];
            pix_data    = wa[n];
            #80;
            pix_data    = wb[n];
            #60;
        end
    end

    // R10: outputs during reset
    initial begin
        #50;
        chk(lane_o == 4'h0, "R10", "lanes in reset", 32'(lane_o), 32'h0);
        chk(lane_oe == 4'hF, "R10", "oe in reset", 32'(lane_oe), 32'hF);
        chk(fclk_o == 1'b0, "R10", "fclk in reset", 32'(fclk_o), 32'h0);
    end

    // frame monitor: deserialize every pixel period
    initial begin
        @(posedge pix_clk);
        for (int m = 0; m < NPIX + 2; m++) begin
            logic [6:0]  fk;
            logic [27:0] rw;
            logic [3:0]  oe_s;
            fk = '0; rw = '0; oe_s = '0;
            for (int k = 0; k < 7; k++) begin
                #10;
                fk[6-k] = fclk_o;
                for (int i = 0; i < 4; i++) rw[i*7 + 6 - k] = lane_o[i];
                if (k == 3) oe_s = lane_oe;
                if (k < 6) #10;
            end
            check_frame(m - 2, fk, rw, oe_s);
            @(posedge pix_clk);
        end
        mon_done = 1'b1;
    end

    initial begin
        fork
            wait (mon_done);
            begin
                #400000;
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule